// File: doc/BRIEF.md
# Coincident-Current Magnetic Core Stack Model

This block is a synthesizable behavioural model of a three-dimensional magnetic core stack. The stack stores W bit planes, and each plane holds X×Y cores. The core at column x, row y of plane b belongs to word (x, y), bit b. Every core is threaded by one column line, one row line and the sense/inhibit line of its plane. That plane line is common to all X×Y cores of bit b. The block has no address decoder and no read/write sequencer. The surrounding logic drives each line directly with a signed unit current, and the model works out what the cores do.

On a clock edge the model forms the net current through every core as the sum of its three line currents. A core switches only when the net current reaches two units in one direction; a single unit, however often it is applied, leaves the core alone. This lets a controller carry out the classic two-step cycle. In the first step, opposing currents on one column and one row zero the selected word, and the planes that held a one raise their sense outputs. In the second step, forward currents restore the word, and single inhibit units on the chosen plane lines keep those bits at zero. A sense output pulses for one cycle whenever any core in its plane actually changed state. A synchronous clear and an asynchronous reset both empty the whole stack without producing any sense pulse.

Top module: `coincident_core_stack`

## Requirements
- R1: Each line drive is a 2-bit code. 2'b01 is +1 (toward one), 2'b11 is −1 (toward zero), and 2'b00 and 2'b10 carry no current. Line i of a drive bus occupies bits [2i+1:2i]. The net current through a core is the sum of its column, row and plane currents.
- R2: A core whose net current lies between −1 and +1 keeps its state, however many times that current is applied.
- R3: A net current of +2 or +3 leaves the core at one. A net current of −2 or −3 leaves it at zero.
- R4: In the cycle after a clock edge, sense_o[b] is 1 exactly when some core of plane b changed state at that edge. Driving a core toward the state it already holds gives sense_o[b] = 0.
- R5: sense_o is a single-cycle pulse. After an edge at which no core changed state, including an edge with no active drive, sense_o is all zeros.
- R6: Several column lines and several row lines may be active at once. Each core follows the R2/R3 rules on its own net current.
- R7: clr = 1 at an edge sets every core to zero and makes sense_o all zeros. This overrides any drive applied in the same cycle.
- R8: rst_n = 0 asynchronously sets every core to zero and sense_o to zero. Release of the reset is synchronised to clk.
- R9: A current on the plane line of bit b acts on every core of plane b, and only on plane b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the whole stack |
| x_drive | input | 2*X | Column line currents, 2 bits per line |
| y_drive | input | 2*Y | Row line currents, 2 bits per line |
| bit_drive | input | 2*W | Plane sense/inhibit line currents, 2 bits per plane |
| sense_o | output | W | Registered per-plane flip pulse |

## Verification
Two functions can fall in the same cycle: a coincident switch of a word and the synchronous clear. The bench provokes the clash by asserting clr in the same cycle as full write currents on an empty word. That write alone would pulse every sense output. The clash is judged correct when sense_o stays all zeros for that cycle and a later destructive read of the same word also returns zeros. A second overlap, a plane inhibit arriving together with a coincident select, is judged by the sense pattern that the write produces and by the pattern that a read of the same word returns afterwards.

// File: rtl/core_pkg.sv
package core_pkg;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_POS  = 2'b01,
    DRV_RSVD = 2'b10,
    DRV_NEG  = 2'b11
  } drive_e;

  typedef logic signed [1:0] unit_t;
  typedef logic signed [2:0] net_t;

  localparam net_t NET_SET = 3'sd2;
  localparam net_t NET_CLR = -3'sd2;

  function automatic unit_t decode_drive(input logic [1:0] code);
    unit_t amp;
    case (drive_e'(code))
      DRV_POS: amp = 2'sb01;
      DRV_NEG: amp = 2'sb11;
      default: amp = 2'sb00;
    endcase
    return amp;
  endfunction

endpackage

// File: rtl/core_line_decode.sv
module core_line_decode
  import core_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N-1:0] code,
  output unit_t          amp [N],
  output logic           active
);

  logic [N-1:0] live;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      amp[i]  = decode_drive(code[2*i +: 2]);
      live[i] = (amp[i] != 2'sb00);
    end
  end

  assign active = |live;

endmodule

// File: rtl/core_cell.sv
module core_cell
  import core_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  unit_t x_amp,
  input  unit_t y_amp,
  input  unit_t s_amp,
  output logic  flip
);

  logic q;
  logic q_d;
  logic ce;
  net_t net;

  always_comb begin
    net = {x_amp[1], x_amp} + {y_amp[1], y_amp} + {s_amp[1], s_amp};
    ce  = en | clr;
    q_d = q;
    if (clr)                 q_d = 1'b0;
    else if (net >= NET_SET) q_d = 1'b1;
    else if (net <= NET_CLR) q_d = 1'b0;
    flip = en & ~clr & (q_d ^ q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (ce) q <= q_d;
  end

  // R2: a sub-threshold net current leaves the core unchanged
  assert_half_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && (net < NET_SET) && (net > NET_CLR)) |=> $stable(q));

  // R3: coincident current toward one
  assert_set_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (net >= NET_SET)) |=> q);

  // R3: coincident current toward zero
  assert_set_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (net <= NET_CLR)) |=> !q);

  // R7: clear empties the core
  assert_clear_core_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);

endmodule

// File: rtl/core_plane.sv
module core_plane
  import core_pkg::*;
#(
  parameter int X = 4,
  parameter int Y = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  unit_t x_amp [X],
  input  unit_t y_amp [Y],
  input  unit_t s_amp,
  output logic  flip_any
);

  localparam int CORES = X * Y;

  logic [CORES-1:0] flips;

  for (genvar ix = 0; ix < X; ix++) begin : g_col
    for (genvar iy = 0; iy < Y; iy++) begin : g_row
      core_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (en),
        .x_amp (x_amp[ix]),
        .y_amp (y_amp[iy]),
        .s_amp (s_amp),
        .flip  (flips[ix*Y + iy])
      );
    end
  end

  assign flip_any = |flips;

endmodule

// File: rtl/coincident_core_stack.sv
module coincident_core_stack
  import core_pkg::*;
#(
  parameter int W = 4,
  parameter int X = 4,
  parameter int Y = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [2*X-1:0] x_drive,
  input  logic [2*Y-1:0] y_drive,
  input  logic [2*W-1:0] bit_drive,
  output logic [W-1:0]   sense_o
);

  logic [1:0]   rst_pipe;
  logic         rst_sync;
  unit_t        x_amp [X];
  unit_t        y_amp [Y];
  unit_t        s_amp [W];
  logic         x_act, y_act, s_act;
  logic         drive_en;
  logic [W-1:0] plane_flip;
  logic [W-1:0] sense_d;

  // R8: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  core_line_decode #(.N(X)) u_xdec (.code(x_drive),   .amp(x_amp), .active(x_act));
  core_line_decode #(.N(Y)) u_ydec (.code(y_drive),   .amp(y_amp), .active(y_act));
  core_line_decode #(.N(W)) u_sdec (.code(bit_drive), .amp(s_amp), .active(s_act));

  assign drive_en = x_act | y_act | s_act;

  for (genvar b = 0; b < W; b++) begin : g_plane
    core_plane #(.X(X), .Y(Y)) u_plane (
      .clk      (clk),
      .rst_n    (rst_sync),
      .clr      (clr),
      .en       (drive_en),
      .x_amp    (x_amp),
      .y_amp    (y_amp),
      .s_amp    (s_amp[b]),
      .flip_any (plane_flip[b])
    );
  end

  always_comb begin
    sense_d = plane_flip;
    if (clr) sense_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) sense_o <= '0;
    else           sense_o <= sense_d;
  end

  // R5: with nothing driven, no sense pulse follows
  assert_quiet_sense_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    (!clr && !drive_en) |=> (sense_o == '0));

  // R7: clear never produces a sense pulse
  assert_clear_silent_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    clr |=> (sense_o == '0));

endmodule

// File: tb/tb_coincident_core_stack.sv
module tb_coincident_core_stack;

  localparam int W = 4;
  localparam int X = 4;
  localparam int Y = 4;
  localparam int NV = 17;

  logic         clk;
  logic         rst_n;
  logic         clr;
  logic [2*X-1:0] x_drive;
  logic [2*Y-1:0] y_drive;
  logic [2*W-1:0] bit_drive;
  logic [W-1:0]   sense_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  coincident_core_stack #(.W(W), .X(X), .Y(Y)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .x_drive(x_drive), .y_drive(y_drive), .bit_drive(bit_drive),
    .sense_o(sense_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Codes: 01 = +1, 11 = -1 (R1); line i at bits [2i+1:2i]
  localparam logic [7:0] TX [NV] = '{
    8'h01, 8'h03, 8'h03, 8'h01, 8'h03, 8'h03, 8'h00, 8'h04, 8'h0F,
    8'h00, 8'h10, 8'h30, 8'h40, 8'hC0, 8'hC0, 8'h0C, 8'h03};
  localparam logic [7:0] TY [NV] = '{
    8'h01, 8'h03, 8'h03, 8'h01, 8'h00, 8'h00, 8'h03, 8'h04, 8'h03,
    8'h00, 8'h40, 8'hC0, 8'h40, 8'hC0, 8'hC0, 8'h0C, 8'h03};
  localparam logic [7:0] TS [NV] = '{
    8'hCC, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h55, 8'hFF, 8'h00,
    8'h00, 8'h3F, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00};
  localparam logic [3:0] TE [NV] = '{
    4'b0101, 4'b0101, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1111,
    4'b0000, 4'b1000, 4'b1000, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000};
  // Row notes:
  // 0  R9 write 0101 to (0,0) with plane inhibits on bits 1,3
  // 1  R4 destructive read (0,0); 2 R4 re-read finds zeros
  // 3  R3 restore 1111; 4,5 R2 repeated column half-select
  // 6  R9 row -1 cancelled by plane +1 on all planes; 7 R2 full inhibit
  // 8  R6 two columns + one row; 9 R5 idle edge
  // 10 write 1000 to (2,3); 11 read it; 12 write 1111 to (3,3)
  // 13 R3 net -3; 14 re-read zeros; 15 (1,1) undisturbed; 16 (0,0) empty

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sense_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] xv, input logic [7:0] yv,
                       input logic [7:0] sv, input logic c);
    @(negedge clk);
    x_drive = xv; y_drive = yv; bit_drive = sv; clr = c;
    @(posedge clk);
    #1;
    x_drive = '0; y_drive = '0; bit_drive = '0; clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0;
    x_drive = '0; y_drive = '0; bit_drive = '0;
    repeat (3) @(negedge clk);
    check("R8 reset state", sense_o, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(TX[i], TY[i], TS[i], 1'b0);
      check($sformatf("R1-table row %0d (R2 R3 R4 R5 R6 R9)", i), sense_o, TE[i]);
    end

    // R5: the pulse lasts one cycle
    apply(8'h01, 8'h01, 8'h00, 1'b0);
    check("R4 write (0,0)", sense_o, 4'b1111);
    @(negedge clk);
    check("R5 pulse ends", sense_o, 4'b0000);

    // R7: clear together with a write to empty word (1,2)
    apply(8'h04, 8'h10, 8'h00, 1'b1);
    check("R7 clear beats write", sense_o, 4'b0000);
    apply(8'h0C, 8'h30, 8'h00, 1'b0);
    check("R7 cleared word (1,2)", sense_o, 4'b0000);
    apply(8'h03, 8'h03, 8'h00, 1'b0);
    check("R7 cleared word (0,0)", sense_o, 4'b0000);

    // R8: asynchronous reset empties the stack
    apply(8'h10, 8'h04, 8'h00, 1'b0);
    check("R8 write (2,1)", sense_o, 4'b1111);
    #1 rst_n = 1'b0;
    #1;
    check("R8 sense during reset", sense_o, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(8'h30, 8'h0C, 8'h00, 1'b0);
    check("R8 word (2,1) after reset", sense_o, 4'b0000);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule